// File: doc/BRIEF.md
# Burst Request Rule Checker

This block is a passive observer that sits beside the address channel and the data channel of a burst-based memory bus. It drives nothing on the bus. It monitors every accepted address request and judges it against the burst legality rules: a wrapping burst may only use certain lengths, an incrementing burst must stay within one 4 KB page, and the beat size must fit the data bus. It then follows the data channel and confirms that the burst carries exactly the encoded number of beats, with the last-beat marker on the final one.

Each broken rule sets its own sticky flag, and any violation also raises a single-cycle pulse. Software or a surrounding checker can poll the flags and clear them with a synchronous clear. Only one burst is followed at a time. A request accepted while a burst is still open counts as an overlap. The open burst keeps being tracked, and the new request is checked against the address rules but its beats are not counted.

Top module: `burst_rule_monitor`

## Requirements
- R1: On an accepted request with type WRAP (type code 2), flag bit 0 is set unless the length field is 1, 3, 7 or 15, which encode 2, 4, 8 or 16 beats.
- R2: On an accepted request with type INCR (type code 1), flag bit 1 is set when the 4 KB page of the last byte differs from the page of the start address. The last byte is the start address rounded down to the beat size, plus (length+1) times 2^size, minus one. An end that passes the top of the address space also counts as a crossing.
- R3: A request of type FIXED (code 0) or WRAP never sets flag bit 1.
- R4: Flag bit 2 is set on an accepted request whose size code gives 2^size bytes per beat above the configured bus width in bytes. This holds for every request type.
- R5: A tracked burst with length field L that carries exactly L+1 beats, with the last marker only on beat L+1, raises no flag. The data payload, including strobes, plays no part in the count. A last marker on any earlier beat sets flag bit 3 and closes the burst.
- R6: A beat without the last marker after L+1 beats have been counted sets flag bit 3 and closes the burst.
- R7: A data beat accepted while no burst is being tracked sets flag bit 3.
- R8: A request accepted while a burst is tracked sets flag bit 4, and the open burst continues to be counted. A request accepted in the same cycle as the closing beat of the open burst is not an overlap and becomes the new tracked burst.
- R9: Flags stay set until the clear input is high at a clock edge. A violation detected at that same edge still sets its flag.
- R10: Flags and the error pulse change on the clock edge that samples the violating handshake. The pulse is high for exactly that one following cycle.
- R11: After reset all flags and the pulse are low and no burst is tracked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| req_valid | input | 1 | Address request valid |
| req_ready | input | 1 | Address request ready |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 3 | Log2 of bytes per beat |
| req_kind | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP |
| req_addr | input | ADDR_W | Start byte address |
| dat_valid | input | 1 | Data beat valid |
| dat_ready | input | 1 | Data beat ready |
| dat_last | input | 1 | Last-beat marker |
| err_flags | output | 5 | Sticky flags: 0 wrap length, 1 page crossing, 2 beat size, 3 beat count, 4 overlap |
| err_pulse | output | 1 | One-cycle pulse on any violation |

## Verification
Every result is due one clock edge after the handshake that triggers it. The address-rule flags and the pulse appear after the edge that accepts the request. The count and overlap flags appear after the edge of the offending beat or request. The bench drives inputs on falling edges and samples them on the next falling edge. Each check therefore reads the state exactly one register stage after its stimulus, and a pulse that lasts too long shows up at the following sample. A sweep over all types, lengths, sizes and page-edge addresses compares the flags with arithmetic in the bench. Directed sequences cover count errors, overlap, back-to-back bursts and clear priority.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;

  localparam int NUM_RULES   = 5;
  localparam int ERR_WRAP    = 0;
  localparam int ERR_PAGE    = 1;
  localparam int ERR_SIZE    = 2;
  localparam int ERR_COUNT   = 3;
  localparam int ERR_OVERLAP = 4;
endpackage

// File: rtl/brm_req_check.sv
module brm_req_check #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 4,
  parameter int SIZE_W    = 3,
  parameter int BUS_BYTES = 4,
  parameter int PAGE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic [LEN_W-1:0]       len,
  input  logic [SIZE_W-1:0]      size,
  input  brm_pkg::burst_kind_e   kind,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   wrap_bad,
  output logic                   page_bad,
  output logic                   size_bad
);
  import brm_pkg::*;

  localparam int BUS_LG = $clog2(BUS_BYTES);
  localparam int AW1    = ADDR_W + 1;

  logic [LEN_W-1:0] len_p1;
  logic             wrap_len_ok;
  logic [AW1-1:0]   lane_mask;
  logic [AW1-1:0]   start_aligned;
  logic [AW1-1:0]   span_bytes;
  logic [AW1-1:0]   last_byte;

  // wrap length must be a power of two of at least two beats
  always_comb begin
    len_p1      = len + LEN_W'(1);
    wrap_len_ok = (len != '0) && ((len & len_p1) == '0);
    wrap_bad    = (kind == BK_WRAP) && !wrap_len_ok;
  end

  always_comb begin
    size_bad = (size > SIZE_W'(BUS_LG));
  end

  // one extra bit so that running off the top of the map counts as a crossing
  always_comb begin
    lane_mask     = {AW1{1'b1}} << size;
    start_aligned = {1'b0, addr} & lane_mask;
    span_bytes    = (AW1'(len) + AW1'(1)) << size;
    last_byte     = start_aligned + span_bytes - AW1'(1);
    page_bad      = (kind == BK_INCR) &&
                    (last_byte[AW1-1:PAGE_BITS] != {1'b0, addr[ADDR_W-1:PAGE_BITS]});
  end

  // R3
  fixed_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (kind != BK_INCR)) |-> !page_bad);

  // R1
  wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap_bad) |-> (kind == BK_WRAP));
endmodule

// File: rtl/brm_beat_tracker.sv
module brm_beat_tracker #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic [LEN_W-1:0] req_len,
  input  logic             beat_fire,
  input  logic             beat_last,
  output logic             count_err,
  output logic             overlap_err
);
  logic             busy_q, busy_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic             final_slot;
  logic             closing;
  logic             slot_free;
  logic             upd_en;

  always_comb begin
    final_slot  = (remain_q == '0);
    closing     = busy_q && beat_fire && (beat_last || final_slot);
    count_err   = beat_fire && (!busy_q || (beat_last != final_slot));
    slot_free   = !busy_q || closing;
    overlap_err = req_fire && !slot_free;
    upd_en      = req_fire || beat_fire;

    busy_d   = busy_q;
    remain_d = remain_q;
    if (busy_q && beat_fire) begin
      if (closing) busy_d = 1'b0;
      else         remain_d = remain_q - LEN_W'(1);
    end
    if (req_fire && slot_free) begin
      busy_d   = 1'b1;
      remain_d = req_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (upd_en) begin
      busy_q   <= busy_d;
      remain_q <= remain_d;
    end
  end

  // R5
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !beat_fire && !req_fire) |=> (busy_q && $stable(remain_q)));

  // R8
  overlap_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> busy_q);

  // R7
  idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && beat_fire) |-> count_err);
endmodule

// File: rtl/brm_err_regs.sv
module brm_err_regs #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] event_vec,
  output logic [N-1:0] flags,
  output logic         pulse
);
  logic [N-1:0] flags_q, flags_d;
  logic         pulse_q, pulse_d;

  always_comb begin
    flags_d = (clr ? '0 : flags_q) | event_vec;
    pulse_d = |event_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      pulse_q <= pulse_d;
    end
  end

  assign flags = flags_q;
  assign pulse = pulse_q;

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R10
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (flags_q != '0));
endmodule

// File: rtl/burst_rule_monitor.sv
module burst_rule_monitor #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 4,
  parameter int BUS_BYTES = 4,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              dat_valid,
  input  logic              dat_ready,
  input  logic              dat_last,
  output logic [4:0]        err_flags,
  output logic              err_pulse
);
  import brm_pkg::*;

  logic                 req_fire, beat_fire;
  logic                 wrap_bad, page_bad, size_bad;
  logic                 count_err, overlap_err;
  logic [NUM_RULES-1:0] events;

  assign req_fire  = req_valid && req_ready;
  assign beat_fire = dat_valid && dat_ready;

  brm_req_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(3),
    .BUS_BYTES(BUS_BYTES), .PAGE_BITS(PAGE_BITS)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .fire(req_fire),
    .len(req_len), .size(req_size), .kind(burst_kind_e'(req_kind)),
    .addr(req_addr),
    .wrap_bad(wrap_bad), .page_bad(page_bad), .size_bad(size_bad)
  );

  brm_beat_tracker #(.LEN_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n),
    .req_fire(req_fire), .req_len(req_len),
    .beat_fire(beat_fire), .beat_last(dat_last),
    .count_err(count_err), .overlap_err(overlap_err)
  );

  always_comb begin
    events              = '0;
    events[ERR_WRAP]    = req_fire && wrap_bad;
    events[ERR_PAGE]    = req_fire && page_bad;
    events[ERR_SIZE]    = req_fire && size_bad;
    events[ERR_COUNT]   = count_err;
    events[ERR_OVERLAP] = overlap_err;
  end

  brm_err_regs #(.N(NUM_RULES)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .event_vec(events), .flags(err_flags), .pulse(err_pulse)
  );

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_fire || beat_fire));

  // R11
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_fire && !beat_fire && !clr) |=> $stable(err_flags));
endmodule

// File: tb/burst_rule_monitor_tb_top.sv
module burst_rule_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        req_valid = 1'b0, req_ready = 1'b1;
  logic [3:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic        dat_valid = 1'b0, dat_ready = 1'b1, dat_last = 1'b0;
  logic [4:0]  err_flags;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_rule_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_size(req_size), .req_kind(req_kind), .req_addr(req_addr),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_last(dat_last),
    .err_flags(err_flags), .err_pulse(err_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic do_req(input int l, input int s, input int k, input logic [31:0] a);
    req_len = 4'(l); req_size = 3'(s); req_kind = 2'(k); req_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_beat(input bit last);
    dat_valid = 1'b1; dat_last = last;
    @(negedge clk);
    dat_valid = 1'b0; dat_last = 1'b0;
  endtask

  function automatic int exp_rules(input int l, input int s, input int k, input logic [31:0] a);
    int r = 0;
    longint unsigned al, lb;
    if (k == 2 && !(l == 1 || l == 3 || l == 7 || l == 15)) r |= 1;
    if (k == 1) begin
      al = longint'(a) & ~((64'd1 << s) - 1);
      lb = al + (longint'(l + 1) << s) - 1;
      if ((lb >> 12) != (longint'(a) >> 12)) r |= 2;
    end
    if ((1 << s) > 4) r |= 4;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] addr_set [6];
    int e;
    addr_set = '{32'h0000_0000, 32'h0000_0FFC, 32'h0000_0F80,
                 32'h0000_1F01, 32'h0000_0FF1, 32'hFFFF_FFF0};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(err_flags == 0 && err_pulse == 0, "R11 reset", {err_pulse, err_flags}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_flags == 0, "R11 after release", err_flags, 0);

    // sweep: R1 R2 R3 R4 R5 R10
    for (int k = 0; k < 3; k++)
      for (int l = 0; l < 16; l++)
        for (int s = 0; s < 8; s++)
          for (int ai = 0; ai < 6; ai++) begin
            do_clear();
            e = exp_rules(l, s, k, addr_set[ai]);
            do_req(l, s, k, addr_set[ai]);
            chk(err_flags == 5'(e), "R1/R2/R3/R4 rule flags", err_flags, e);
            chk(err_pulse == (e != 0), "R10 pulse", err_pulse, int'(e != 0));
            for (int b = 0; b <= l; b++) do_beat(b == l);
            chk(err_flags == 5'(e), "R5 exact count", err_flags, e);
            chk(err_pulse == 0, "R10 pulse one cycle", err_pulse, 0);
          end

    // R5 early last
    do_clear();
    do_req(3, 1, 1, 32'h100);
    do_beat(0); do_beat(1);
    chk(err_flags == 5'h08, "R5 early last", err_flags, 8);
    chk(err_pulse == 1, "R10 early last pulse", err_pulse, 1);
    do_beat(0);
    chk(err_flags == 5'h08, "R7 beat after closed", err_flags, 8);

    // R6 missing last
    do_clear();
    do_req(1, 0, 1, 32'h200);
    do_beat(0); do_beat(0);
    chk(err_flags == 5'h08, "R6 missing last", err_flags, 8);
    do_clear();
    do_req(0, 0, 1, 32'h200);
    do_beat(1);
    chk(err_flags == 5'h00, "R6 closed burst frees tracker", err_flags, 0);

    // R7 stray beat
    do_clear();
    do_beat(1);
    chk(err_flags == 5'h08, "R7 idle beat", err_flags, 8);

    // R8 overlap
    do_clear();
    do_req(3, 2, 1, 32'h300);
    do_req(0, 0, 1, 32'h0);
    chk(err_flags == 5'h10, "R8 overlap", err_flags, 16);
    for (int b = 0; b < 4; b++) do_beat(b == 3);
    chk(err_flags == 5'h10, "R8 open burst still counted", err_flags, 16);

    // R8 back to back on closing beat
    do_clear();
    do_req(1, 2, 1, 32'h400);
    do_beat(0);
    req_len = 4'd0; req_size = 3'd2; req_kind = 2'd1; req_addr = 32'h500;
    req_valid = 1'b1; dat_valid = 1'b1; dat_last = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; dat_valid = 1'b0; dat_last = 1'b0;
    chk(err_flags == 5'h00, "R8 no overlap on closing beat", err_flags, 0);
    do_beat(1);
    chk(err_flags == 5'h00, "R8 second burst tracked", err_flags, 0);

    // R9 sticky and clear priority
    do_clear();
    do_req(2, 0, 2, 32'h0);
    do_req(0, 0, 0, 32'h0);
    chk(err_flags == 5'h11, "R9 set", err_flags, 17);
    for (int b = 0; b < 3; b++) do_beat(b == 2);
    repeat (3) @(negedge clk);
    chk(err_flags == 5'h11, "R9 sticky", err_flags, 17);
    clr = 1'b1; dat_valid = 1'b1; dat_last = 1'b1;
    @(negedge clk);
    clr = 1'b0; dat_valid = 1'b0; dat_last = 1'b0;
    chk(err_flags == 5'h08, "R9 set beats clear", err_flags, 8);
    do_clear();
    chk(err_flags == 5'h00, "R9 cleared", err_flags, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule